// File: doc/BRIEF.md
# Master clock selector and prescaler

The block builds two derived clocks from a small set of free-running source clocks. A source-select field picks one source. A power-of-two prescaler divides it down to the processor clock. A second divider derives the master clock from the processor clock. Source changes are glitch-free: the outgoing source is gated off only while it is low, the gate stays closed for a few cycles of synchronisation, and the incoming source is admitted only while it is low.

Software writes one configuration word. It then waits until a ready flag returns, either by polling the read port or by taking an interrupt that has its own enable bit. Each write should change only one field, and software should wait for ready between writes.

All logic runs on one fast system clock. Each source is synchronised by two flops. The derived clocks are registered levels that are produced in the system clock domain.

Top module: `mclk_gen`

## Requirements
- R1: After reset, rd_data reads 0x80: source 0, prescale code 0, divider code 0 and ready (bit 7) set. irq is 0, and the master clock period equals the period of src_clk[0].
- R2: Configuration bits 1:0 select src_clk[index]. In steady state the master clock period equals the source period times the prescale factor times the divider factor.
- R3: Prescale bits 4:2 hold a code n. Codes 0 to 6 divide the selected source by 2^n. Code 7 behaves as code 6, a division by 64.
- R4: Divider bits 6:5 hold a code. Codes 0, 1 and 2 give a master clock period of 1, 2 and 4 processor clock periods. Code 3 gives 1. A rising edge of the master clock follows only a cycle in which the processor clock was high.
- R5: A write with wr_addr 0 stores wr_data bits 6:0 and ignores bit 7. From the next cycle the ready flag reads 0, and rd_data reads {ready, stored bits 6:0}.
- R6: Ready sets again only when two conditions hold. No source switch is pending, and the master clock has risen twice after the write; the cycle straight after the write does not count. So at least one full period at the new setting lies between the write and ready. Ready never rises in the cycle after a write, and it stays set while no configuration write occurs.
- R7: A source change proceeds in four steps:
  - it waits for the synchronised old source to be low;
  - it closes the gate;
  - it keeps the gate closed for at least two cycles and until the new source is low;
  - it then opens the gate to the new source.
  No processor clock pulse during a switch is shorter than the shorter source half-period times the prescale factor. The processor clock does not rise in the cycle after a gated-off cycle.
- R8: A write with wr_addr 1 sets the interrupt enable from wr_data bit 0 and leaves the configuration and ready unchanged. irq equals ready AND enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_clk | input | 4 | Source clocks, index 0 is the slow clock |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 selects configuration, 1 selects interrupt enable |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | {ready, divider code, prescale code, source select} |
| pclk | output | 1 | Processor clock |
| mclk | output | 1 | Master clock |
| rdy | output | 1 | New setting has taken effect |
| irq | output | 1 | Ready interrupt, gated by the enable |

## Verification
The assertions assume three things about the inputs:
- every source clock stays high and low for at least two system cycles;
- each source changes away from the sampling edge;
- no configuration write arrives while a switch is still in progress.

The bench meets these conditions in three ways. It toggles each source on the falling system edge with half-periods of 2 to 8 cycles. It waits for ready after every write. Each write in its vector table changes exactly one field.

// File: rtl/mclk_pkg.sv
package mclk_pkg;
    localparam int SEL_W     = 2;
    localparam int NSRC      = 1 << SEL_W;
    localparam int PRESC_W   = 3;
    localparam int MDIV_W    = 2;
    localparam int PCNT_W    = 1 << PRESC_W;
    localparam int MCNT_W    = 1 << MDIV_W;
    localparam int CFG_W     = SEL_W + PRESC_W + MDIV_W;
    localparam int DW        = CFG_W + 1;
    localparam int PRESC_MAX = 6;

    typedef struct packed {
        logic [MDIV_W-1:0]  mdiv;
        logic [PRESC_W-1:0] presc;
        logic [SEL_W-1:0]   src;
    } cfg_t;

    typedef enum logic [1:0] {
        SW_RUN   = 2'd0,
        SW_DRAIN = 2'd1,
        SW_HOLD  = 2'd2
    } sw_state_e;

    // Prescale code to shift amount; codes above the maximum clamp to it.
    function automatic logic [PRESC_W-1:0] presc_shift(input logic [PRESC_W-1:0] code);
        return (code > PRESC_W'(PRESC_MAX)) ? PRESC_W'(PRESC_MAX) : code;
    endfunction

    // Divider code to shift amount; the all-ones code acts as divide-by-1.
    function automatic logic [MDIV_W-1:0] mdiv_shift(input logic [MDIV_W-1:0] code);
        return (code == '1) ? '0 : code;
    endfunction
endpackage

// File: rtl/mclk_src_switch.sv
module mclk_src_switch
    import mclk_pkg::*;
#(
    parameter int N_SRC    = NSRC,
    parameter int S_W      = SEL_W,
    parameter int HOLD_CYC = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] src_clk,
    input  logic [S_W-1:0]   target,
    output logic             gclk,
    output logic             gated_off,
    output logic             busy
);
    localparam int HCNT_W = $clog2(HOLD_CYC + 1);

    typedef struct packed {
        logic [N_SRC-1:0] s1;
        logic [N_SRC-1:0] s2;
        logic [S_W-1:0]   cur;
        sw_state_e        st;
        logic [HCNT_W-1:0] hcnt;
        logic             gclk;
    } sw_t;

    sw_t sw_q, sw_d;

    always_comb begin
        sw_d    = sw_q;
        sw_d.s1 = src_clk;
        sw_d.s2 = sw_q.s1;
        case (sw_q.st)
            SW_RUN: begin
                if (target != sw_q.cur) sw_d.st = SW_DRAIN;
            end
            SW_DRAIN: begin
                // close the gate only while the outgoing source is low
                if (!sw_q.s2[sw_q.cur]) begin
                    sw_d.st   = SW_HOLD;
                    sw_d.cur  = target;
                    sw_d.hcnt = '0;
                end
            end
            SW_HOLD: begin
                if (target != sw_q.cur) begin
                    sw_d.cur  = target;
                    sw_d.hcnt = '0;
                end else if (sw_q.hcnt != HCNT_W'(HOLD_CYC)) begin
                    sw_d.hcnt = sw_q.hcnt + 1'b1;
                end else if (!sw_q.s2[sw_q.cur]) begin
                    sw_d.st = SW_RUN;
                end
            end
            default: sw_d.st = SW_RUN;
        endcase
        sw_d.gclk = (sw_d.st != SW_HOLD) ? sw_q.s2[sw_d.cur] : 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sw_q <= '{s1: '0, s2: '0, cur: '0, st: SW_RUN, hcnt: '0, gclk: 1'b0};
        end else begin
            sw_q <= sw_d;
        end
    end

    assign gclk      = sw_q.gclk;
    assign gated_off = (sw_q.st == SW_HOLD);
    assign busy      = (sw_q.st != SW_RUN);
endmodule

// File: rtl/mclk_divider.sv
module mclk_divider
    import mclk_pkg::*;
#(
    parameter int P_W = PRESC_W,
    parameter int M_W = MDIV_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           gclk,
    input  logic [P_W-1:0] presc_code,
    input  logic [M_W-1:0] mdiv_code,
    input  logic           clr_p,
    input  logic           clr_m,
    output logic           pclk,
    output logic           mclk
);
    localparam int PC_W = 1 << P_W;
    localparam int MC_W = 1 << M_W;

    typedef struct packed {
        logic            g_prev;
        logic [PC_W-1:0] pcnt;
        logic            pclk;
        logic            p_prev;
        logic [MC_W-1:0] mcnt;
        logic            mclk;
    } div_t;

    div_t dv_q, dv_d;
    logic [P_W-1:0] ps;
    logic [M_W-1:0] ms;

    always_comb begin
        dv_d        = dv_q;
        ps          = presc_shift(presc_code);
        ms          = mdiv_shift(mdiv_code);
        dv_d.g_prev = gclk;
        dv_d.p_prev = dv_q.pclk;

        if (clr_p) begin
            dv_d.pcnt = '0;
            dv_d.pclk = 1'b0;
        end else begin
            if (gclk && !dv_q.g_prev) dv_d.pcnt = dv_q.pcnt + 1'b1;
            dv_d.pclk = (ps == '0) ? gclk : dv_d.pcnt[ps - 1'b1];
        end

        if (clr_m) begin
            dv_d.mcnt = '0;
            dv_d.mclk = 1'b0;
        end else begin
            if (dv_q.pclk && !dv_q.p_prev) dv_d.mcnt = dv_q.mcnt + 1'b1;
            dv_d.mclk = (ms == '0) ? dv_q.pclk : dv_d.mcnt[ms - 1'b1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dv_q <= '0;
        end else begin
            dv_q <= dv_d;
        end
    end

    assign pclk = dv_q.pclk;
    assign mclk = dv_q.mclk;
endmodule

// File: rtl/mclk_ready.sv
module mclk_ready #(
    parameter int RDY_EDGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_cfg,
    input  logic busy,
    input  logic mclk,
    output logic rdy
);
    localparam int CNT_W = $clog2(RDY_EDGES + 1);

    typedef struct packed {
        logic             rdy;
        logic [CNT_W-1:0] cnt;
        logic             m_prev;
        logic             wr_prev;
    } rdy_t;

    rdy_t rd_q, rd_d;

    always_comb begin
        rd_d         = rd_q;
        rd_d.m_prev  = mclk;
        rd_d.wr_prev = wr_cfg;
        if (wr_cfg) begin
            rd_d.rdy = 1'b0;
            rd_d.cnt = '0;
        end else if (!rd_q.rdy) begin
            if (busy || rd_q.wr_prev) begin
                rd_d.cnt = '0;
            end else if (mclk && !rd_q.m_prev) begin
                if (rd_q.cnt == CNT_W'(RDY_EDGES - 1)) rd_d.rdy = 1'b1;
                else rd_d.cnt = rd_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q <= '{rdy: 1'b1, cnt: '0, m_prev: 1'b0, wr_prev: 1'b0};
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rdy = rd_q.rdy;
endmodule

// File: rtl/mclk_gen.sv
module mclk_gen
    import mclk_pkg::*;
#(
    parameter int HOLD_CYC  = 2,
    parameter int RDY_EDGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSRC-1:0] src_clk,
    input  logic            wr_en,
    input  logic            wr_addr,
    input  logic [DW-1:0]   wr_data,
    output logic [DW-1:0]   rd_data,
    output logic            pclk,
    output logic            mclk,
    output logic            rdy,
    output logic            irq
);
    typedef struct packed {
        cfg_t cfg;
        logic ie;
    } top_t;

    top_t tp_q, tp_d;
    cfg_t wdat;
    logic wr_cfg, clr_p, clr_m;
    logic gclk, sw_off, sw_busy;
    logic unused_bit7;

    assign unused_bit7 = wr_data[DW-1];

    always_comb begin
        tp_d   = tp_q;
        wdat   = cfg_t'(wr_data[CFG_W-1:0]);
        wr_cfg = wr_en && !wr_addr;
        clr_p  = wr_cfg && (wdat.presc != tp_q.cfg.presc);
        clr_m  = wr_cfg && (wdat.mdiv != tp_q.cfg.mdiv);
        if (wr_cfg) tp_d.cfg = wdat;
        if (wr_en && wr_addr) tp_d.ie = wr_data[0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tp_q <= '0;
        end else begin
            tp_q <= tp_d;
        end
    end

    mclk_src_switch #(
        .N_SRC   (NSRC),
        .S_W     (SEL_W),
        .HOLD_CYC(HOLD_CYC)
    ) u_sw (
        .clk      (clk),
        .rst_n    (rst_n),
        .src_clk  (src_clk),
        .target   (tp_q.cfg.src),
        .gclk     (gclk),
        .gated_off(sw_off),
        .busy     (sw_busy)
    );

    mclk_divider #(
        .P_W(PRESC_W),
        .M_W(MDIV_W)
    ) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .gclk      (gclk),
        .presc_code(tp_q.cfg.presc),
        .mdiv_code (tp_q.cfg.mdiv),
        .clr_p     (clr_p),
        .clr_m     (clr_m),
        .pclk      (pclk),
        .mclk      (mclk)
    );

    mclk_ready #(
        .RDY_EDGES(RDY_EDGES)
    ) u_rdy (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_cfg(wr_cfg),
        .busy  (sw_busy),
        .mclk  (mclk),
        .rdy   (rdy)
    );

    assign rd_data = {rdy, tp_q.cfg};
    assign irq     = rdy & tp_q.ie;
endmodule

// File: rtl/mclk_gen_chk.sv
module mclk_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic wr_en,
    input logic wr_addr,
    input logic rdy,
    input logic irq,
    input logic pclk,
    input logic mclk,
    input logic sw_off
);
    logic cfg_wr;
    assign cfg_wr = wr_en && !wr_addr;

    AST_RDY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> !rdy); // R5
    AST_RDY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (rdy && !cfg_wr) |=> rdy); // R6
    AST_RDY_NOT_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy) |-> !$past(cfg_wr)); // R6
    AST_NO_EDGE_WHEN_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        sw_off |=> !$rose(pclk)); // R7
    AST_MCLK_FOLLOWS_PCLK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mclk) |-> $past(pclk)); // R4
    AST_IRQ_NEEDS_RDY: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> rdy); // R8
endmodule

bind mclk_gen mclk_gen_chk u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .rdy    (rdy),
    .irq    (irq),
    .pclk   (pclk),
    .mclk   (mclk),
    .sw_off (sw_off)
);

// File: tb/sim_mclk_gen.sv
`timescale 1ns/1ps
module sim_mclk_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       s0 = 1'b0, s1 = 1'b0, s2 = 1'b0, s3 = 1'b0;
    logic [3:0] src_clk;
    logic       wr_en = 1'b0;
    logic       wr_addr = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       pclk, mclk, rdy, irq;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    localparam int H0 = 8, H1 = 3, H2 = 5, H3 = 2;

    typedef struct packed {
        logic [7:0]  data;
        logic [15:0] period;
        logic [15:0] minp;
        logic [3:0]  req;
    } vec_t;

    // data, expected mclk period, minimum pclk pulse during a switch (0: no switch), requirement
    localparam vec_t VEC [0:12] = '{
        '{8'h81, 16'd6,    16'd3,   4'd2},
        '{8'h05, 16'd12,   16'd0,   4'd3},
        '{8'h25, 16'd24,   16'd0,   4'd4},
        '{8'h2D, 16'd96,   16'd0,   4'd3},
        '{8'h2F, 16'd64,   16'd16,  4'd7},
        '{8'h4F, 16'd128,  16'd0,   4'd4},
        '{8'h5B, 16'd1024, 16'd0,   4'd3},
        '{8'h5F, 16'd1024, 16'd0,   4'd3},
        '{8'h7F, 16'd256,  16'd0,   4'd4},
        '{8'h7E, 16'd640,  16'd128, 4'd7},
        '{8'h62, 16'd10,   16'd0,   4'd3},
        '{8'h02, 16'd10,   16'd0,   4'd4},
        '{8'h00, 16'd16,   16'd5,   4'd7}
    };

    assign src_clk = {s3, s2, s1, s0};

    mclk_gen u0 (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_clk(src_clk),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .rd_data(rd_data),
        .pclk   (pclk),
        .mclk   (mclk),
        .rdy    (rdy),
        .irq    (irq)
    );

    initial forever #2.5 clk = ~clk;
    initial forever begin repeat (H0) @(negedge clk); s0 = ~s0; end
    initial forever begin repeat (H1) @(negedge clk); s1 = ~s1; end
    initial forever begin repeat (H2) @(negedge clk); s2 = ~s2; end
    initial forever begin repeat (H3) @(negedge clk); s3 = ~s3; end

    function automatic string tag(input int r);
        case (r)
            2: return "R2";
            3: return "R3";
            4: return "R4";
            7: return "R7";
            default: return "R?";
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // waits for ready, tracking the shortest completed pclk pulse
    task automatic wait_rdy(output int elapsed, output int minp);
        int   t = 0;
        int   last = -1;
        logic pv = pclk;
        minp = 1 << 30;
        while (!rdy && t < 20000) begin
            @(negedge clk);
            t++;
            if (pclk != pv) begin
                if (last >= 0 && (t - last) < minp) minp = t - last;
                last = t;
            end
            pv = pclk;
        end
        elapsed = t;
    endtask

    task automatic meas(output int per);
        int   t = 0;
        int   first = -1;
        logic pv = mclk;
        per = -1;
        while (t < 6000) begin
            @(negedge clk);
            t++;
            if (mclk && !pv) begin
                if (first < 0) first = t;
                else begin
                    per = t - first;
                    break;
                end
            end
            pv = mclk;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL R6 watchdog actual=%0d expected=%0d", 150000, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int per, el, mp;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(rd_data == 8'h80, "R1", rd_data, 8'h80);
        check(irq == 1'b0, "R1", irq, 0);
        meas(per);
        check(per == 2 * H0, "R1", per, 2 * H0);

        // R8 interrupt enable write leaves configuration and ready alone
        write_reg(1'b1, 8'h01);
        check(rdy == 1'b1, "R8", rdy, 1);
        check(rd_data == 8'h80, "R8", rd_data, 8'h80);
        check(irq == 1'b1, "R8", irq, 1);

        for (int i = 0; i < 13; i++) begin
            write_reg(1'b0, VEC[i].data);
            check(rdy == 1'b0, "R5", rdy, 0);
            check(rd_data == {1'b0, VEC[i].data[6:0]}, "R5", rd_data, {1'b0, VEC[i].data[6:0]});
            check(irq == 1'b0, "R8", irq, 0);
            wait_rdy(el, mp);
            check(rdy == 1'b1, "R6", rdy, 1);
            check(el >= int'(VEC[i].period) - 1, "R6", el, VEC[i].period);
            if (VEC[i].minp != 0)
                check(mp >= int'(VEC[i].minp), "R7", mp, VEC[i].minp);
            meas(per);
            check(per == int'(VEC[i].period), tag(VEC[i].req), per, VEC[i].period);
            meas(per);
            check(per == int'(VEC[i].period), "R2", per, VEC[i].period);
            check(rdy == 1'b1, "R6", rdy, 1);
            check(irq == 1'b1, "R8", irq, 1);
        end

        write_reg(1'b1, 8'h00);
        check(irq == 1'b0, "R8", irq, 0);
        check(rd_data == 8'h80, "R8", rd_data, 8'h80);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule